// File: doc/BRIEF.md
# Keyboard Serial Receive Controller

This block receives byte frames from a keyboard-style device over a two-wire open-drain link with one clock line and one data line. Both lines are sampled into the system clock domain. The data level is captured on each falling edge of the device clock. Each frame carries a low start bit, eight data bits with the least significant bit first, an odd parity bit and a stop bit.

When the stop bit arrives, the byte, a parity-error flag and the stop-bit value are stored, and a buffer-full flag is set. The controller then pulls the clock line low by itself. This keeps the device from sending another byte until software has read the buffer and cleared the flag. Clearing the flag releases the line, and the receiver waits for the next start bit.

Software controls the block through level control inputs: pin enable, receive enable and interrupt enable. A pulse input clears the buffer-full flag. Readback outputs report the synchronized line levels. The host-to-device direction and any timeout supervision are not part of this block.

Top module: `kbd_rx_ctrl`

## Requirements
- R1: A frame is received as one start bit (0), eight data bits with bit 0 sent first, one parity bit and one stop bit; the data bits appear on `rx_byte_o` with bit 0 in position 0.
- R2: The data line is sampled only on falling edges of the device clock; changes on the data line while the clock is high have no effect on the stored byte.
- R3: `rx_armed_o` goes to 1 only in a cycle where `pin_en_i` and `rx_en_i` are 1 and both synchronized lines read 1. It stays 1 until either enable drops.
- R4: `kclk_pin_o` and `kdat_pin_o` follow the clock and data line levels after the synchronizer delay.
- R5: After the stop bit, `buf_full_o` becomes 1 and `kclk_drv_n_o` becomes 0, which pulls the clock line low. No further frame is accepted and the stored byte is unchanged until the flag is cleared.
- R6: `irq_o` is 1 exactly while `buf_full_o` and `irq_en_i` are both 1, so it rises in the same cycle as the flag.
- R7: `par_err_o` is 1 when the number of 1s across the eight data bits and the parity bit is even, and 0 when it is odd.
- R8: `stop_bit_o` holds the level sampled for the stop bit of the last stored frame.
- R9: A one-cycle pulse on `buf_clr_i` while `buf_full_o` is 1 clears the flag, sets `kclk_drv_n_o` back to 1, and keeps `rx_armed_o` at 1 so the next frame is received.
- R10: Dropping `rx_en_i` in the middle of a frame discards the partial frame. After re-arming, the next complete frame is received correctly.
- R11: A falling clock edge that samples the data line high while waiting for a start bit is ignored, and the receiver keeps waiting for a start bit.
- R12: `kdat_drv_n_o` is always 1, because the data line is never driven.
- R13: With `pin_en_i` at 0, the receiver does not arm and `kclk_drv_n_o` is 1, even while `buf_full_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_en_i | input | 1 | Enables use of the link pins |
| rx_en_i | input | 1 | Receive enable request |
| irq_en_i | input | 1 | Interrupt enable |
| buf_clr_i | input | 1 | One-cycle pulse that clears the buffer-full flag |
| kclk_i | input | 1 | Clock line level |
| kdat_i | input | 1 | Data line level |
| kclk_drv_n_o | output | 1 | Clock line drive enable, active low (0 pulls low) |
| kdat_drv_n_o | output | 1 | Data line drive enable, active low |
| rx_armed_o | output | 1 | Receiver is armed |
| buf_full_o | output | 1 | A received byte is waiting |
| par_err_o | output | 1 | Odd-parity check of the stored frame failed |
| stop_bit_o | output | 1 | Stop-bit level of the stored frame |
| rx_byte_o | output | 8 | Stored received byte |
| kclk_pin_o | output | 1 | Synchronized clock line level |
| kdat_pin_o | output | 1 | Synchronized data line level |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the device holds each data level steady around every falling clock edge. They also assume each clock phase lasts longer than the synchronizer delay, so every edge appears as exactly one detected fall. The bench's device model keeps each clock phase eight system cycles long and changes data only while the clock is high. It models the clock line as the wired AND of the device's clock and the controller's drive, so the inhibit pull-down is visible to both sides. Clear pulses last one cycle and are issued only after the flag has been observed.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  typedef enum logic [1:0] {
    RX_WAIT_START = 2'd0,
    RX_DATA       = 2'd1,
    RX_PARITY     = 2'd2,
    RX_STOP       = 2'd3
  } rx_state_t;
endpackage

// File: rtl/kbd_rst_sync.sv
module kbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/kbd_pin_sync.sv
module kbd_pin_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;
    logic              last_q;

    always_comb sync_d = {sync_q[STAGES-2:0], pin_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        last_q <= 1'b1;
      end else begin
        sync_q <= sync_d;
        last_q <= sync_q[STAGES-1];
      end
    end

    assign level_o[g] = sync_q[STAGES-1];
    assign fall_o[g]  = last_q & ~sync_q[STAGES-1];
  end
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 armed_i,
  input  logic                 hold_i,
  input  logic                 fall_i,
  input  logic                 dat_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 par_o,
  output logic                 stop_o
);
  localparam int CNT_W = $clog2(DATA_BITS + 1);

  rx_state_t            st_q, st_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 par_q, par_d;
  logic                 run;

  assign run = armed_i & ~hold_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    par_d = par_q;
    if (!run) begin
      st_d  = RX_WAIT_START;
      cnt_d = '0;
    end else if (fall_i) begin
      unique case (st_q)
        RX_WAIT_START: begin
          cnt_d = '0;
          if (!dat_i) st_d = RX_DATA;
        end
        RX_DATA: begin
          sh_d  = {dat_i, sh_q[DATA_BITS-1:1]};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_BITS - 1)) st_d = RX_PARITY;
        end
        RX_PARITY: begin
          par_d = dat_i;
          st_d  = RX_STOP;
        end
        RX_STOP: begin
          st_d  = RX_WAIT_START;
          cnt_d = '0;
        end
        default: st_d = RX_WAIT_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_WAIT_START;
      cnt_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      par_q <= par_d;
    end
  end

  assign done_o = run & fall_i & (st_q == RX_STOP);
  assign byte_o = sh_q;
  assign par_o  = par_q;
  assign stop_o = dat_i;

  // R1: the bit counter never runs past the data width
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DATA_BITS));

  // R10: losing the arm returns the receiver to waiting for a start bit
  a_r10_disarm_resets: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |=> (st_q == RX_WAIT_START) && (cnt_q == '0));

  // R11: a high level at a fall while waiting does not leave the wait state
  a_r11_high_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fall_i && dat_i && st_q == RX_WAIT_START) |=> st_q == RX_WAIT_START);
endmodule

// File: rtl/kbd_rx_regs.sv
module kbd_rx_regs #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_en_i,
  input  logic                 rx_en_i,
  input  logic                 irq_en_i,
  input  logic                 clr_i,
  input  logic                 line_clk_i,
  input  logic                 line_dat_i,
  input  logic                 done_i,
  input  logic [DATA_BITS-1:0] byte_i,
  input  logic                 par_i,
  input  logic                 stop_i,
  output logic                 armed_o,
  output logic                 full_o,
  output logic                 par_err_o,
  output logic                 stop_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 irq_o,
  output logic                 clk_drv_n_o
);
  logic                 armed_q, armed_d;
  logic                 full_q, full_d;
  logic                 perr_q, perr_d;
  logic                 stop_q, stop_d;
  logic [DATA_BITS-1:0] byte_q, byte_d;
  logic                 bus_idle;

  assign bus_idle = line_clk_i & line_dat_i;

  always_comb begin
    armed_d = pin_en_i & rx_en_i & (armed_q | bus_idle);
    full_d  = full_q;
    perr_d  = perr_q;
    stop_d  = stop_q;
    byte_d  = byte_q;
    if (done_i) begin
      full_d = 1'b1;
      byte_d = byte_i;
      perr_d = ~(^{byte_i, par_i});
      stop_d = stop_i;
    end else if (clr_i) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      full_q  <= 1'b0;
      perr_q  <= 1'b0;
      stop_q  <= 1'b0;
      byte_q  <= '0;
    end else begin
      armed_q <= armed_d;
      full_q  <= full_d;
      perr_q  <= perr_d;
      stop_q  <= stop_d;
      byte_q  <= byte_d;
    end
  end

  assign armed_o     = armed_q;
  assign full_o      = full_q;
  assign par_err_o   = perr_q;
  assign stop_o      = stop_q;
  assign byte_o      = byte_q;
  assign irq_o       = full_q & irq_en_i;
  assign clk_drv_n_o = ~(full_q & pin_en_i);

  // R3: arming happens only from an idle bus with both enables on
  a_r3_arm_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(bus_idle && pin_en_i && rx_en_i));

  // R9: the flag only falls after a clear request
  a_r9_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> $past(clr_i));

  // R5: the stored byte is stable while the flag stays set
  a_r5_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && $past(full_q)) |-> $stable(byte_q));
endmodule

// File: rtl/kbd_rx_ctrl.sv
module kbd_rx_ctrl #(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_en_i,
  input  logic                 rx_en_i,
  input  logic                 irq_en_i,
  input  logic                 buf_clr_i,
  input  logic                 kclk_i,
  input  logic                 kdat_i,
  output logic                 kclk_drv_n_o,
  output logic                 kdat_drv_n_o,
  output logic                 rx_armed_o,
  output logic                 buf_full_o,
  output logic                 par_err_o,
  output logic                 stop_bit_o,
  output logic [DATA_BITS-1:0] rx_byte_o,
  output logic                 kclk_pin_o,
  output logic                 kdat_pin_o,
  output logic                 irq_o
);
  localparam int LINES = 2;
  localparam int L_CLK = 0;
  localparam int L_DAT = 1;

  logic                 srst_n;
  logic [LINES-1:0]     lvl, fall;
  logic                 frame_done;
  logic [DATA_BITS-1:0] frame_byte;
  logic                 frame_par, frame_stop;

  kbd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  kbd_pin_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (srst_n),
    .pin_i   ({kdat_i, kclk_i}),
    .level_o (lvl),
    .fall_o  (fall)
  );

  kbd_frame_rx #(.DATA_BITS(DATA_BITS)) u_frame (
    .clk     (clk),
    .rst_n   (srst_n),
    .armed_i (rx_armed_o),
    .hold_i  (buf_full_o),
    .fall_i  (fall[L_CLK]),
    .dat_i   (lvl[L_DAT]),
    .done_o  (frame_done),
    .byte_o  (frame_byte),
    .par_o   (frame_par),
    .stop_o  (frame_stop)
  );

  kbd_rx_regs #(.DATA_BITS(DATA_BITS)) u_regs (
    .clk         (clk),
    .rst_n       (srst_n),
    .pin_en_i    (pin_en_i),
    .rx_en_i     (rx_en_i),
    .irq_en_i    (irq_en_i),
    .clr_i       (buf_clr_i),
    .line_clk_i  (lvl[L_CLK]),
    .line_dat_i  (lvl[L_DAT]),
    .done_i      (frame_done),
    .byte_i      (frame_byte),
    .par_i       (frame_par),
    .stop_i      (frame_stop),
    .armed_o     (rx_armed_o),
    .full_o      (buf_full_o),
    .par_err_o   (par_err_o),
    .stop_o      (stop_bit_o),
    .byte_o      (rx_byte_o),
    .irq_o       (irq_o),
    .clk_drv_n_o (kclk_drv_n_o)
  );

  assign kdat_drv_n_o = 1'b1;
  assign kclk_pin_o   = lvl[L_CLK];
  assign kdat_pin_o   = lvl[L_DAT];

  // R5: a completed frame sets the flag on the next edge
  a_r5_done_sets_full: assert property (@(posedge clk) disable iff (!srst_n)
    frame_done |=> buf_full_o);

  // R5: no frame completes while the buffer is full
  a_r5_no_done_when_full: assert property (@(posedge clk) disable iff (!srst_n)
    buf_full_o |-> !frame_done);

  // R6: interrupt agrees with flag and enable
  a_r6_irq_follows_flag: assert property (@(posedge clk) disable iff (!srst_n)
    irq_o == (buf_full_o && irq_en_i));

  // R13: with pins disabled the clock line is never driven
  a_r13_no_drive_when_off: assert property (@(posedge clk) disable iff (!srst_n)
    !pin_en_i |-> kclk_drv_n_o);
endmodule

// File: tb/kbd_rx_ctrl_tb_top.sv
module kbd_rx_ctrl_tb_top;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_en, rx_en, irq_en, buf_clr;
  logic       dev_clk, dev_dat;
  logic       kclk_line, kdat_line;
  logic       kclk_drv_n, kdat_drv_n, armed, full, perr, stopb, kclk_pin, kdat_pin, irq;
  logic [7:0] rx_byte;

  int n_total = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  assign kclk_line = dev_clk & kclk_drv_n;
  assign kdat_line = dev_dat & kdat_drv_n;

  kbd_rx_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_en_i     (pin_en),
    .rx_en_i      (rx_en),
    .irq_en_i     (irq_en),
    .buf_clr_i    (buf_clr),
    .kclk_i       (kclk_line),
    .kdat_i       (kdat_line),
    .kclk_drv_n_o (kclk_drv_n),
    .kdat_drv_n_o (kdat_drv_n),
    .rx_armed_o   (armed),
    .buf_full_o   (full),
    .par_err_o    (perr),
    .stop_bit_o   (stopb),
    .rx_byte_o    (rx_byte),
    .kclk_pin_o   (kclk_pin),
    .kdat_pin_o   (kdat_pin),
    .irq_o        (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dev_bit(input logic b);
    dev_dat = ~b;
    wait_cyc(HALF / 2);
    dev_dat = b;
    wait_cyc(HALF / 2);
    dev_clk = 1'b0;
    wait_cyc(HALF);
    dev_clk = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic par, input logic stp);
    dev_bit(1'b0);
    for (int i = 0; i < 8; i++) dev_bit(d[i]);
    dev_bit(par);
    dev_bit(stp);
    dev_dat = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic clear_flag();
    buf_clr = 1'b1;
    wait_cyc(1);
    buf_clr = 1'b0;
    wait_cyc(2);
  endtask

  task automatic t_reset_and_arm();
    chk("R13 reset drive", kclk_drv_n, 1);
    chk("R12 data drive", kdat_drv_n, 1);
    chk("R5 reset full", full, 0);
    dev_dat = 1'b0;
    wait_cyc(5);
    chk("R4 data readback low", kdat_pin, 0);
    chk("R4 clock readback high", kclk_pin, 1);
    rx_en = 1'b1;
    wait_cyc(5);
    chk("R13 no arm without pin enable", armed, 0);
    pin_en = 1'b1;
    wait_cyc(5);
    chk("R3 no arm while data low", armed, 0);
    dev_dat = 1'b1;
    wait_cyc(5);
    chk("R3 arm on idle bus", armed, 1);
    chk("R4 data readback high", kdat_pin, 1);
  endtask

  task automatic t_basic_frame();
    irq_en = 1'b1;
    send_frame(8'hA5, ~^8'hA5, 1'b1);
    chk("R1 byte", rx_byte, 8'hA5);
    chk("R2 data glitches while high ignored", rx_byte, 8'hA5);
    chk("R5 full set", full, 1);
    chk("R5 clock pulled low", kclk_drv_n, 0);
    chk("R4 inhibit seen on clock readback", kclk_pin, 0);
    chk("R6 irq with enable", irq, 1);
    chk("R7 good parity", perr, 0);
    chk("R8 stop high", stopb, 1);
    irq_en = 1'b0;
    wait_cyc(1);
    chk("R6 irq masked", irq, 0);
    chk("R12 data never driven", kdat_drv_n, 1);
  endtask

  task automatic t_inhibit_and_clear();
    send_frame(8'h3F, 1'b1, 1'b1);
    chk("R5 byte held during inhibit", rx_byte, 8'hA5);
    chk("R5 still full", full, 1);
    pin_en = 1'b0;
    wait_cyc(1);
    chk("R13 drive released with pins off", kclk_drv_n, 1);
    pin_en = 1'b1;
    wait_cyc(1);
    clear_flag();
    chk("R9 flag cleared", full, 0);
    chk("R9 clock released", kclk_drv_n, 1);
    wait_cyc(4);
    chk("R9 still armed", armed, 1);
    send_frame(8'h81, ~^8'h81, 1'b1);
    chk("R9 next frame received", rx_byte, 8'h81);
    clear_flag();
  endtask

  task automatic t_parity_stop();
    send_frame(8'h0F, ^8'h0F, 1'b0);
    chk("R7 bad parity flagged", perr, 1);
    chk("R8 stop low captured", stopb, 0);
    chk("R7 byte with bad parity", rx_byte, 8'h0F);
    clear_flag();
  endtask

  task automatic t_abort_mid_frame();
    dev_bit(1'b0);
    for (int i = 0; i < 4; i++) dev_bit(1'b0);
    rx_en = 1'b0;
    wait_cyc(4);
    chk("R10 disarmed", armed, 0);
    dev_dat = 1'b1;
    rx_en = 1'b1;
    wait_cyc(5);
    chk("R10 re-armed", armed, 1);
    send_frame(8'hC3, ~^8'hC3, 1'b1);
    chk("R10 clean frame after abort", rx_byte, 8'hC3);
    chk("R10 full after abort", full, 1);
    clear_flag();
  endtask

  task automatic t_glitch_start();
    dev_bit(1'b1);
    wait_cyc(HALF);
    chk("R11 no frame from high start", full, 0);
    send_frame(8'h3C, ~^8'h3C, 1'b1);
    chk("R11 frame after glitch", rx_byte, 8'h3C);
    chk("R11 parity after glitch", perr, 0);
    clear_flag();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    pin_en  = 1'b0;
    rx_en   = 1'b0;
    irq_en  = 1'b0;
    buf_clr = 1'b0;
    dev_clk = 1'b1;
    dev_dat = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset_and_arm();
    t_basic_frame();
    t_inhibit_and_clear();
    t_parity_stop();
    t_abort_mid_frame();
    t_glitch_start();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule